// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Unit

This block collects single-cycle event pulses from a link controller into a register of sticky flags, and combines them with a read/write enable register to drive one active-low interrupt request. There are eight event sources: transmit done, end of packet, receive overflow, transmit underrun, go-ahead, frame abort, receive threshold and transmit threshold. A flag that is masked still latches and can still be read, but it does not pull the request line low.

A simple register port with read and write strobes and a one-bit address selects either the flag register or the enable register. Reading the flag register returns its contents and clears every flag as a side effect. The only exception is an event that arrives in the same cycle as that read, which stays set. A status output mirrors the request line in positive polarity so that a poller can see it without inverting it.

Top module: `irq_flag_unit`

## Requirements
- R1: While reset is held and after it is released, all flags and all enables are zero, `irq_n` is 1, `irq_stat` is 0 and `rd_data` is 0.
- R2: A pulse on `evt[i]` sets flag bit i at the next clock edge, and the flag stays set until the flag register is read. The bit positions are: 0 transmit done, 1 end of packet, 2 receive overflow, 3 transmit underrun, 4 go-ahead, 5 frame abort, 6 receive threshold, 7 transmit threshold.
- R3: A flag whose enable bit is 0 still latches and reads back as 1, but `irq_n` stays 1.
- R4: A read with `addr`=0 returns the flag register on `rd_data` in the cycle after the strobe and clears all flags at that same edge.
- R5: `irq_n` is 0 in every cycle in which at least one bit is set in both the flag register and the enable register, and 1 otherwise. It changes in the cycle after the edge that updates either register.
- R6: `irq_stat` is always the inverse of `irq_n`.
- R7: A write with `addr`=1 loads the enable register, which uses the same bit positions as the flags. A read with `addr`=1 returns the enable register in the next cycle and leaves the flags unchanged.
- R8: An event pulse in the same cycle as a flag-register read is absent from that read's data, and its flag is set after the read.
- R9: A write with `addr`=0 changes neither the flags nor the enables.
- R10: `rd_data` holds the value of the last read until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NEV | Single-cycle event pulses, one per flag |
| addr | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | NEV | Write data |
| rd_data | output | NEV | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |
| irq_stat | output | 1 | High whenever the request is asserted |

## Verification
Each event, write or read takes effect at the first clock edge after it is presented. Flags, enables, `irq_n` and `irq_stat` therefore show their new values one clock after the stimulus, and read data appears one clock after the read strobe. The driver presents every stimulus on a falling edge and pushes the expected read value into a queue. The monitor samples one nanosecond after the following rising edge, pops one item for each read, and compares the request line against a model of the flags and enables that has just been updated.

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [NEV-1:0] wr_data,
  output logic [NEV-1:0] rd_data,
  output logic           irq_n,
  output logic           irq_stat
);

  localparam logic SEL_FLAG = 1'b0;
  localparam logic SEL_EN   = 1'b1;

  logic [NEV-1:0] flag_q;
  logic [NEV-1:0] en_q;
  logic           flag_rd;

  assign flag_rd = rd_en && (addr == SEL_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= (flag_rd ? '0 : flag_q) | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en && addr == SEL_EN) begin
      en_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= (addr == SEL_EN) ? en_q : flag_q;
    end
  end

  assign irq_n    = ~|(flag_q & en_q);
  assign irq_stat = ~irq_n;

endmodule

module irq_flag_unit_chk #(
  parameter int NEV = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] evt,
  input logic           addr,
  input logic           wr_en,
  input logic           rd_en,
  input logic [NEV-1:0] wr_data,
  input logic [NEV-1:0] flag_q,
  input logic [NEV-1:0] en_q,
  input logic           irq_n,
  input logic           irq_stat
);

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_q & $past(evt)) == $past(evt)));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_en && !addr)) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_en && !addr)) |-> (flag_q == $past(evt)));

  a_r5_release_on_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && addr) && $past(wr_data) == '0) |-> irq_n);

  a_r6_stat_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat == !irq_n);

  a_r9_flag_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && !addr)) |-> $stable(en_q));

endmodule

bind irq_flag_unit irq_flag_unit_chk #(.NEV(NEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .wr_data(wr_data), .flag_q(flag_q), .en_q(en_q),
  .irq_n(irq_n), .irq_stat(irq_stat)
);

// File: tb/irq_flag_unit_tb.sv
module irq_flag_unit_tb;
  localparam int W = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] evt = '0;
  logic         addr = 0;
  logic         wr_en = 0;
  logic         rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq_n;
  logic         irq_stat;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mflag = '0;
  logic [W-1:0] men = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  irq_flag_unit #(.NEV(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_n(irq_n), .irq_stat(irq_stat)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] ev, input logic wr, input logic rd,
                       input logic ad, input logic [W-1:0] wd, input string tag);
    @(negedge clk);
    evt = ev; wr_en = wr; rd_en = rd; addr = ad; wr_data = wd;
    if (rd) begin
      exp_q.push_back(ad ? men : mflag);
      tag_q.push_back(tag);
    end
    if (rd && !ad) mflag = '0;
    mflag = mflag | ev;
    if (wr && ad) men = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, 0, 0, 0, '0, "");
  endtask

  // monitor: scoreboard pop and request-line comparison
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      chk("R5 irq_n", {7'b0, irq_n}, {7'b0, ~|(mflag & men)});
      chk("R6 irq_stat", {7'b0, irq_stat}, {7'b0, ~irq_n});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq_n in reset", {7'b0, irq_n}, 8'h01);
    chk("R1 irq_stat in reset", {7'b0, irq_stat}, 8'h00);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1;
    idle(1);
    drive('0, 0, 1, 0, '0, "R1 flags after reset");
    drive('0, 0, 1, 1, '0, "R1 enables after reset");
    idle(1);

    // R2: each position latches and is sticky
    for (int i = 0; i < W; i++) begin
      drive(8'(1 << i), 0, 0, 0, '0, "");
      idle(2);
      drive('0, 0, 1, 0, '0, "R2 single event position");
    end
    drive(8'h81, 0, 0, 0, '0, "");
    drive(8'h04, 0, 0, 0, '0, "");
    idle(3);
    drive('0, 0, 1, 0, '0, "R2 sticky accumulate");

    // R3: masked flag readable, no request
    drive(8'h10, 0, 0, 0, '0, "");
    @(posedge clk); #1;
    chk("R3 masked irq_n", {7'b0, irq_n}, 8'h01);
    drive('0, 0, 1, 0, '0, "R3 masked flag readable");
    drive('0, 0, 1, 0, '0, "R4 cleared after read");

    // R5/R7: enable and request
    drive('0, 1, 0, 1, 8'h09, "");
    drive('0, 0, 1, 1, '0, "R7 enable readback");
    drive(8'h08, 0, 0, 0, '0, "");
    @(posedge clk); #1;
    chk("R5 irq asserted", {7'b0, irq_n}, 8'h00);
    drive('0, 0, 1, 1, '0, "R7 enable read keeps flags");
    drive('0, 0, 1, 0, '0, "R7 flags intact after enable read");
    @(posedge clk); #1;
    chk("R4 irq released after read", {7'b0, irq_n}, 8'h01);

    // R3: masking an active flag releases request, flag stays
    drive(8'h01, 0, 0, 0, '0, "");
    drive('0, 1, 0, 1, 8'h00, "");
    @(posedge clk); #1;
    chk("R3 masked later irq_n", {7'b0, irq_n}, 8'h01);
    drive('0, 0, 1, 0, '0, "R3 flag kept when masked");

    // R8: event coincident with read
    drive(8'h20, 0, 0, 0, '0, "");
    drive(8'h02, 0, 1, 0, '0, "R8 read excludes coincident event");
    drive('0, 0, 1, 0, '0, "R8 coincident event survives");

    // R9: flag-address write ignored
    drive('0, 1, 0, 1, 8'h55, "");
    drive(8'h40, 0, 0, 0, '0, "");
    drive('0, 1, 0, 0, 8'hFF, "");
    drive('0, 0, 1, 1, '0, "R9 enables unchanged");
    drive('0, 0, 1, 0, '0, "R9 flags unchanged");

    // R10: rd_data holds
    idle(1);
    drive(8'h03, 0, 0, 0, '0, "");
    idle(3);
    chk("R10 rd_data holds", rd_data, 8'h40);
    drive('0, 0, 1, 0, '0, "R10 next read");
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule